// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing front end of a byte-addressed nonvolatile memory that sits on a two-wire serial bus as a slave. A fast system clock samples SCL and SDA. Both inputs pass through a synchronizer and a stability filter. Start and stop conditions are then recovered from the filtered lines. The engine shifts words in and out most significant bit first. It acknowledges in the ninth clock by pulling its open-drain output enable.

It decodes the device select word and tracks the protocol phases: the memory address bytes, the write data bytes, the dummy write that sets up a random read, and the read data bytes. Each protocol event is handed to a neighbouring address counter and page-write sequencer as a one-cycle pulse. That neighbour supplies the byte at the current address on `rd_data`. It reports an internal write in progress on `wr_busy`.

One parameter, `ADDR_W`, selects the memory size:
- With 10 or 11 address bits, the top address bits travel in the device select word, and one address byte follows.
- With 12 or more address bits, all three select bits are compared with the pins, and two address bytes follow.

Top module: `i2c_mem_slave`

## Requirements
- R1: A change on SCL or SDA is accepted only after the synchronized input has differed from the accepted level for FILT_LEN consecutive clocks; shorter pulses have no effect on the protocol.
- R2: A start is filtered SDA falling while filtered SCL is high; a stop is SDA rising while SCL is high. After a stop, the block ignores bus traffic until the next start.
- R3: The device select word after a start is acknowledged (SDA pulled low during the ninth clock) only if bits 7..4 are 1010 and the compared select bits match `dev_pins`. Select bits 3,2,1 correspond to pins 2,1,0. With ADDR_W=10, only bit 3 is compared; with ADDR_W=11, none is compared; with ADDR_W>=12, all three are compared. Bit 0 set means read. On a mismatch, no acknowledge is given and the block ignores the bus until the next start.
- R4: While `wr_busy` is high, a matching device select word is not acknowledged.
- R5: A write-type select is followed by two address bytes (high first) when ADDR_W>=12, or by one otherwise. After the last address byte, `addr_load` pulses with `addr_val` set as follows:
  - ADDR_W>=12: the low ADDR_W bits of {high byte, low byte}.
  - ADDR_W<12: the low ADDR_W bits of {select bits 3..1, address byte}.
  Every address byte is acknowledged.
- R6: Each data byte after the address bytes gives a `wr_strobe` pulse, with the byte on `wr_data` in the same cycle, and is acknowledged.
- R7: A stop after at least one complete data byte pulses `wr_stop`. A stop after only address bytes, or during a partial byte, does not.
- R8: After an acknowledged read select, each byte is taken from `rd_data` after the SCL falling edge that ends the previous ninth clock. It is driven most significant bit first, with each new bit after an SCL falling edge.
- R9: After each read byte, SDA is released for the master's ninth bit and `rd_next` pulses once. A master acknowledge of 0 starts the next byte. An acknowledge of 1 leaves SDA released, with nothing more sent and no further `rd_next`, until a start or stop.
- R10: A start in any phase discards a partial byte and restarts at the device select word. A repeated start after the address bytes turns the access into a read from the loaded address.
- R11: `sda_oe` is 0 after reset and only becomes 1 while filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data as seen on the bus |
| dev_pins | input | 3 | Hard-wired device select pins |
| wr_busy | input | 1 | Internal write cycle in progress |
| rd_data | input | 8 | Byte at the current address |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_load | output | 1 | Pulse: load `addr_val` into the address counter |
| addr_val | output | ADDR_W | Assembled memory address |
| wr_strobe | output | 1 | Pulse: `wr_data` holds a received data byte |
| wr_data | output | 8 | Received data byte |
| rd_next | output | 1 | Pulse: a read byte was consumed, advance the address |
| wr_stop | output | 1 | Pulse: write sequence closed by a stop, start the internal write |

## Verification
Two instances share one bus: a 10-bit instance (one address byte, select bits carry a9..a8) and a 13-bit instance (two address bytes, all pins compared). Each select word therefore shows one instance answering and the other staying silent, and the acknowledge alone tells whether the compare mask of each size is right.

The stimulus patterns cover the following cases:
- A short SDA dip with no real start, and a short SCL dip inside an address bit, to separate the filter from edge detection.
- A full write, a write closed after the address only, and a write aborted mid-byte, to show when the write-commit pulse must appear.
- A busy poll.
- A random read with a dummy write followed by a current-address read.
- A sequence of ACK, ACK, NACK, then clocking on after the NACK, to separate the continue, stop-sending and released states.
- Bad pins, a bad device code, and a start in the middle of the select word.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W   = 13,
  parameter int FILT_LEN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_pins,
  input  logic              wr_busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_val,
  output logic              wr_strobe,
  output logic [7:0]        wr_data,
  output logic              rd_next,
  output logic              wr_stop
);
  localparam int         CW       = $clog2(FILT_LEN + 1);
  localparam logic       TWO      = (ADDR_W > 11);
  localparam int         NPG      = TWO ? 0 : ADDR_W - 8;
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << NPG);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT, S_WAIT} st_t;

  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [1:0]    sync;
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync <= 2'b11;
        cnt  <= '0;
        lvl  <= 1'b1;
      end else begin
        sync <= {sync[0], raw[g]};
        if (sync[1] == lvl) cnt <= '0;
        else if (cnt == CW'(FILT_LEN - 1)) begin
          lvl <= sync[1];
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign filt[g] = lvl;
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh, hi;
  logic [2:0] devhi;
  logic       ack_ok, ack_on, tx_on, rw, wrote;
  logic [7:0] byte_in;
  logic       match;

  assign byte_in = {sh[6:0], sda_f};
  assign match   = (byte_in[7:4] == 4'b1010) &&
                   (((byte_in[3:1] ^ dev_pins) & CMP_MASK) == 3'b000) && !wr_busy;
  assign sda_oe  = ack_on | (tx_on & ~sh[7]);
  assign wr_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      hi        <= '0;
      devhi     <= '0;
      ack_ok    <= 1'b0;
      ack_on    <= 1'b0;
      tx_on     <= 1'b0;
      rw        <= 1'b0;
      wrote     <= 1'b0;
      addr_load <= 1'b0;
      addr_val  <= '0;
      wr_strobe <= 1'b0;
      rd_next   <= 1'b0;
      wr_stop   <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      wr_strobe <= 1'b0;
      rd_next   <= 1'b0;
      wr_stop   <= 1'b0;
      if (start_c) begin
        st     <= S_DEV;
        bitcnt <= '0;
        ack_on <= 1'b0;
        tx_on  <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_c) begin
        wr_stop <= (st == S_WDAT) && wrote;
        st      <= S_IDLE;
        bitcnt  <= '0;
        ack_on  <= 1'b0;
        tx_on   <= 1'b0;
        wrote   <= 1'b0;
      end else if (st != S_IDLE && st != S_WAIT) begin
        if (scl_rise) begin
          if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 1'b1;
            if (st != S_RDAT) sh <= byte_in;
            if (bitcnt == 4'd7) begin
              case (st)
                S_DEV: begin
                  ack_ok <= match;
                  rw     <= byte_in[0];
                  devhi  <= byte_in[3:1];
                end
                S_AHI: begin
                  ack_ok <= 1'b1;
                  hi     <= byte_in;
                end
                S_ALO: begin
                  ack_ok    <= 1'b1;
                  addr_load <= 1'b1;
                  addr_val  <= TWO ? ADDR_W'({hi, byte_in}) : ADDR_W'({devhi, byte_in});
                end
                S_WDAT: begin
                  ack_ok    <= 1'b1;
                  wr_strobe <= 1'b1;
                  wrote     <= 1'b1;
                end
                default: ;
              endcase
            end
          end else begin
            bitcnt <= '0;
            case (st)
              S_RDAT: begin
                rd_next <= 1'b1;
                if (sda_f) st <= S_WAIT;
              end
              S_DEV:         st <= !ack_ok ? S_IDLE : rw ? S_RDAT : TWO ? S_AHI : S_ALO;
              S_AHI:         st <= S_ALO;
              S_ALO, S_WDAT: st <= S_WDAT;
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd0) begin
            ack_on <= 1'b0;
            if (st == S_RDAT) begin
              sh    <= rd_data;
              tx_on <= 1'b1;
            end
          end else if (bitcnt == 4'd8) begin
            if (st == S_RDAT) tx_on <= 1'b0;
            else ack_on <= ack_ok;
          end else if (st == S_RDAT) begin
            sh <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_f,
  input logic sda_oe,
  input logic addr_load,
  input logic wr_strobe,
  input logic rd_next,
  input logic wr_stop
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R11
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, wr_strobe, rd_next, wr_stop})); // R5
  AST_CAPTURE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load || wr_strobe) |-> scl_f); // R6
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stop |-> (scl_f && sda_f)); // R7
  AST_RELEASE_FOR_MASTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |-> (!sda_oe && scl_f)); // R9
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .sda_oe(sda_oe),
  .addr_load(addr_load), .wr_strobe(wr_strobe), .rd_next(rd_next), .wr_stop(wr_stop)
);

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int QT = 20;
  localparam int HT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, scl_glitch = 1'b0;
  logic busy_n = 1'b0, busy_w = 1'b0;
  logic oe_n, oe_w, sda_bus;
  assign sda_bus = sda_m & ~oe_n & ~oe_w;

  logic        al_n, ws_n, rn_n, st_n, al_w, ws_w, rn_w, st_w;
  logic [9:0]  av_n;
  logic [12:0] av_w;
  logic [7:0]  wd_n, wd_w, rdd_n, rdd_w;
  logic [9:0]  cnt_n;
  logic [12:0] cnt_w;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign rdd_n = pat(13'(cnt_n));
  assign rdd_w = pat(cnt_w);

  i2c_mem_slave #(.ADDR_W(10), .FILT_LEN(4)) u_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .dev_pins(3'b011),
    .wr_busy(busy_n), .rd_data(rdd_n), .sda_oe(oe_n), .addr_load(al_n),
    .addr_val(av_n), .wr_strobe(ws_n), .wr_data(wd_n), .rd_next(rn_n), .wr_stop(st_n));

  i2c_mem_slave #(.ADDR_W(13), .FILT_LEN(4)) u_i2c_mem_slave_wide (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .dev_pins(3'b101),
    .wr_busy(busy_w), .rd_data(rdd_w), .sda_oe(oe_w), .addr_load(al_w),
    .addr_val(av_w), .wr_strobe(ws_w), .wr_data(wd_w), .rd_next(rn_w), .wr_stop(st_w));

  int la_n, la_w, nal_w, nws_n, nws_w, lwd_n, lwd_w, nrn_n, nrn_w, nst_n, nst_w;
  int bad_oe;
  logic oe_n_q, oe_w_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt_n <= '0; cnt_w <= '0;
      la_n <= -1; la_w <= -1; nal_w <= 0; nws_n <= 0; nws_w <= 0;
      lwd_n <= -1; lwd_w <= -1; nrn_n <= 0; nrn_w <= 0; nst_n <= 0; nst_w <= 0;
      bad_oe <= 0; oe_n_q <= 1'b0; oe_w_q <= 1'b0;
    end else begin
      if (al_n) begin cnt_n <= av_n; la_n <= int'(av_n); end
      else if (rn_n) begin cnt_n <= cnt_n + 1'b1; nrn_n <= nrn_n + 1; end
      if (al_w) begin cnt_w <= av_w; la_w <= int'(av_w); nal_w <= nal_w + 1; end
      else if (rn_w) begin cnt_w <= cnt_w + 1'b1; nrn_w <= nrn_w + 1; end
      if (ws_n) begin nws_n <= nws_n + 1; lwd_n <= int'(wd_n); end
      if (ws_w) begin nws_w <= nws_w + 1; lwd_w <= int'(wd_w); end
      if (st_n) nst_n <= nst_n + 1;
      if (st_w) nst_w <= nst_w + 1;
      oe_n_q <= oe_n;
      oe_w_q <= oe_w;
      if (((oe_n && !oe_n_q) || (oe_w && !oe_w_q)) && scl) bad_oe <= bad_oe + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(QT); scl = 1'b1; tick(QT); sda_m = 1'b0; tick(QT); scl = 1'b0; tick(QT);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(QT); scl = 1'b1; tick(QT); sda_m = 1'b1; tick(QT);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sda_m = b[i]; tick(QT); scl = 1'b1;
      if (scl_glitch && i == 4) begin
        tick(15); scl = 1'b0; tick(2); scl = 1'b1; tick(HT - 17);
      end else tick(HT);
      scl = 1'b0; tick(QT);
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(QT); scl = 1'b1; tick(QT); ack = sda_bus; tick(QT); scl = 1'b0; tick(QT);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(QT); scl = 1'b1; tick(QT); d[i] = sda_bus; tick(QT); scl = 1'b0; tick(QT);
    end
    sda_m = mack; tick(QT); scl = 1'b1; tick(HT); scl = 1'b0; tick(QT); sda_m = 1'b1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R1 to R11 unfinished)");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(10);
    chk("R11 reset oe narrow", int'(oe_n), 0);
    chk("R11 reset oe wide", int'(oe_w), 0);

    sda_m = 1'b0; tick(3); sda_m = 1'b1; tick(HT);
    scl = 1'b0; tick(QT);
    wbyte(8'hA6, a);
    chk("R1 short SDA dip is no start", int'(a), 1);
    bus_stop();

    bus_start();
    wbyte(8'hA6, a); chk("R3 narrow select ack", int'(a), 0);
    chk("R3 wide ignores other pins", nal_w, 0);
    scl_glitch = 1'b1; wbyte(8'h5A, a); scl_glitch = 1'b0;
    chk("R5 address byte ack", int'(a), 0);
    chk("R1 R5 address with SCL glitch", la_n, 'h35A);
    wbyte(8'h11, a); chk("R6 data ack 1", int'(a), 0);
    wbyte(8'h22, a); chk("R6 data ack 2", int'(a), 0);
    chk("R6 strobe count", nws_n, 2);
    chk("R6 last data", lwd_n, 'h22);
    chk("R7 no commit before stop", nst_n, 0);
    bus_stop(); tick(10);
    chk("R7 commit on stop", nst_n, 1);

    scl = 1'b0; tick(QT);
    wbyte(8'hA6, a); chk("R2 ignored after stop", int'(a), 1);
    bus_stop();

    busy_n = 1'b1;
    bus_start(); wbyte(8'hA6, a); chk("R4 busy poll nack", int'(a), 1);
    bus_stop(); busy_n = 1'b0;

    bus_start(); wbyte(8'hA2, a); chk("R3 select ack A1A0 not compared", int'(a), 0);
    wbyte(8'h10, a); chk("R5 address ack", int'(a), 0);
    chk("R5 narrow address uses select bits", la_n, 'h110);
    bus_start();
    wbyte(8'hA1, a); chk("R10 repeated start read select ack", int'(a), 0);
    rbyte(1'b0, d); chk("R8 R10 random read byte 0", int'(d), int'(pat(13'h110)));
    rbyte(1'b0, d); chk("R9 sequential byte 1", int'(d), int'(pat(13'h111)));
    rbyte(1'b1, d); chk("R9 sequential byte 2", int'(d), int'(pat(13'h112)));
    rbyte(1'b1, d); chk("R9 released after nack", int'(d), 'hFF);
    chk("R9 read advance count", nrn_n, 3);
    bus_stop(); tick(10);
    chk("R7 no commit after read", nst_n, 1);

    bus_start(); wbyte(8'hAA, a); chk("R3 wide select ack", int'(a), 0);
    wbyte(8'hE7, a); chk("R5 wide high byte ack", int'(a), 0);
    chk("R5 no load after high byte", nal_w, 0);
    wbyte(8'h3C, a); chk("R5 wide low byte ack", int'(a), 0);
    chk("R5 wide address", la_w, 'h073C);
    wbyte(8'hA5, a); chk("R6 wide data ack", int'(a), 0);
    bus_stop(); tick(10);
    chk("R6 wide data", lwd_w, 'hA5);
    chk("R7 wide commit", nst_w, 1);

    bus_start(); wbyte(8'hAB, a); chk("R3 wide read select ack", int'(a), 0);
    rbyte(1'b1, d); chk("R8 current address read", int'(d), int'(pat(13'h073C)));
    chk("R9 wide advance", nrn_w, 1);
    bus_stop();

    bus_start(); wbyte(8'hA8, a); chk("R3 wrong pins nack", int'(a), 1);
    bus_stop();
    bus_start(); wbyte(8'h66, a); chk("R3 wrong device code nack", int'(a), 1);
    bus_stop();

    bus_start(); send_bits(8'hA6, 4);
    bus_start(); wbyte(8'hAA, a); chk("R10 start mid select word", int'(a), 0);
    wbyte(8'h00, a); wbyte(8'h05, a);
    chk("R10 address after restart", la_w, 'h0005);
    bus_stop(); tick(10);
    chk("R7 stop after address only", nst_w, 1);

    bus_start(); wbyte(8'hA6, a); wbyte(8'h20, a);
    chk("R5 second narrow address", la_n, 'h320);
    send_bits(8'hFF, 5); bus_stop(); tick(10);
    chk("R10 partial byte dropped", nws_n, 2);
    chk("R7 partial byte no commit", nst_n, 1);
    chk("R11 oe rose only while SCL low", bad_oe, 0);

    done = 1'b1;
    finish_run();
  end
endmodule